// File: doc/BRIEF.md
# Synchronized Four-Channel Clock Divider and Output Stage

This block takes one fast source clock and turns it into four divided output channels. Each channel has its own integer divide ratio. A shared synchronization hold stops every channel divider at the same moment and starts them again on the same source clock edge. Channels that share a ratio therefore stay phase-aligned, and no channel emits a shortened pulse when it is restarted. The hold can be requested by four sources, OR'ed together: a software level bit, a lock-detector edge, the falling edge of a selectable external pin, and a strobe from configuration loading.

After the divider, each channel goes through an output-mapping stage. This stage turns the divided waveform into a positive pin value, a negative pin value and one output-enable flag per pin. The mapping follows a per-channel 3-bit mode, a polarity-invert bit and a single-ended phase-flip bit. Analog driver levels and drive strength are handled outside this block. A simple write port loads the divide ratios, the channel controls and the sync-source controls. Every register write lands on the clock edge where `cfg_we` is sampled high.

Top module: `clkdist_fanout`

## Requirements
- R1: While reset is low, and right after it, every ratio field is 0, every channel mode is 000 and every invert bit is clear. During reset, all positive and negative pins read 0 and all eight output-enable flags read 1.
- R2: A ratio field value R (address 0 to 3 for channels 0 to 3, bits 9:0) gives divisor D = 1 when R = 0, and D = R otherwise. After a hold ends, a channel is high for ceil(D/2) cycles and then low for floor(D/2) cycles, repeating. The first high cycle is seen one cycle after the first cycle in which the dividers are released. D = 1 gives a constant high level.
- R3: While the hold is active, every divided waveform is 0. All channels restart on the same edge, so channels with equal ratios produce identical waveforms.
- R4: A ratio written while the dividers run has no effect on the output until the next hold.
- R5: Sync-control register (address 8) bit 0 is a level. While it is set, the outputs stay in the hold state. Clearing it releases the dividers.
- R6: Sync-control bit 1 enables restart on a rising edge of `lock_freq_i`, and bit 2 enables restart on a rising edge of `lock_phase_i`. With its enable bit clear, an edge on either input has no effect, and a lock input that stays high does not trigger again.
- R7: Sync-control bit 3 enables the pin source, and bits 6:4 select one of the eight `mf_pin_i` inputs. A falling edge on the selected pin, after a two-flop synchronizer, restarts the dividers. A rising edge, or an edge on an unselected pin, has no effect.
- R8: A one-cycle high on `cfg_load_sync_i` restarts the dividers.
- R9: Channel control bit 3 (addresses 4 to 7 for channels 0 to 3) inverts the channel's logic level in every mode.
- R10: Mode 000 (control bits 2:0) drives both pins with both enables high. Control bit 4 clear makes the negative pin equal the positive pin; bit 4 set makes it the complement.
- R11: Mode 001 drives only the positive pin: the negative pin reads 0 and its enable is low. Mode 010 drives only the negative pin, which follows the mode 000 bit 4 rule: the positive pin reads 0 and its enable is low.
- R12: Modes 100 and 101 give a differential pair (negative pin = NOT positive pin) with both enables high. Modes 011, 110 and 111 give the same pair with both enables low. Bit 4 has no effect outside modes 000 and 010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 10 | Register write data |
| lock_freq_i | input | 1 | Frequency-lock indication (synchronous) |
| lock_phase_i | input | 1 | Phase-lock indication (synchronous) |
| mf_pin_i | input | 8 | Asynchronous multifunction inputs |
| cfg_load_sync_i | input | 1 | Sync strobe from configuration loading |
| out_p_o | output | 4 | Positive pin value per channel |
| out_n_o | output | 4 | Negative pin value per channel |
| oe_p_o | output | 4 | Positive pin enable per channel |
| oe_n_o | output | 4 | Negative pin enable per channel |

## Verification
The bench checks the exact restart latency of each sync source. A pin synchronizer one stage too short or too long, or a pulse source that is registered twice, shifts every following waveform by a cycle. It checks odd ratios and the ratio-zero case, where an off-by-one in the high-phase length makes an asymmetric clock come out symmetric or constant. Lock, pin and ratio-write stimuli are applied while a long expected waveform is already queued, so a design that triggers on the wrong edge, on a disabled source, or that loads a new ratio too early breaks the queued waveform. Each output mode is checked with polarity and phase-flip combinations, so a misrouted enable or a phase flip leaking into the differential modes shows up on the pins.

// File: rtl/clkdist_pkg.sv
// Package: shared types for the synchronized clock distribution block.
// Assumes the sync-control register keeps the bit order the bench and
// software rely on (direct, freq enable, phase enable, pin enable, select).
package clkdist_pkg;

    localparam int MF_SEL_W = 3;
    localparam int NUM_MF   = 1 << MF_SEL_W;

    typedef enum logic [2:0] {
        MODE_CMOS_BOTH = 3'b000,
        MODE_CMOS_P    = 3'b001,
        MODE_CMOS_N    = 3'b010,
        MODE_OFF       = 3'b011,
        MODE_DIFF_A    = 3'b100,
        MODE_DIFF_B    = 3'b101,
        MODE_RSV6      = 3'b110,
        MODE_RSV7      = 3'b111
    } out_mode_e;

    typedef struct packed {
        logic      cmos_flip;
        logic      pol_inv;
        out_mode_e mode;
    } ch_ctrl_t;

    typedef struct packed {
        logic [MF_SEL_W-1:0] pin_sel;
        logic                pin_en;
        logic                auto_phase_en;
        logic                auto_freq_en;
        logic                direct;
    } sync_ctrl_t;

    localparam int CTRL_W = $bits(ch_ctrl_t);
    localparam int SCTL_W = $bits(sync_ctrl_t);

endpackage

// File: rtl/clkdist_regs.sv
// Module: register file for ratios, channel controls and sync control.
// Assumes write data is at least as wide as the widest control field.
// Map: 0..NUM_CH-1 ratios, NUM_CH..2*NUM_CH-1 controls, 2*NUM_CH sync.
module clkdist_regs
    import clkdist_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DIV_W  = 10,
    parameter int ADDR_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [ADDR_W-1:0]             cfg_addr,
    input  logic [DIV_W-1:0]              cfg_wdata,
    output logic [NUM_CH-1:0][DIV_W-1:0]  ratio_cfg,
    output ch_ctrl_t [NUM_CH-1:0]         ch_ctrl,
    output sync_ctrl_t                    sync_ctrl
);

    localparam int CTRL_BASE = NUM_CH;
    localparam int SYNC_ADDR = 2 * NUM_CH;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch_regs
        // Holds the divide ratio of channel i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ratio_cfg[i] <= '0;
            else if (cfg_we && cfg_addr == ADDR_W'(i))
                ratio_cfg[i] <= cfg_wdata;
        end

        // Holds the mode, polarity and phase-flip bits of channel i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ch_ctrl[i] <= '0;
            else if (cfg_we && cfg_addr == ADDR_W'(CTRL_BASE + i))
                ch_ctrl[i] <= ch_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        end
    end

    // Holds the sync-source control fields.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_ctrl <= '0;
        else if (cfg_we && cfg_addr == ADDR_W'(SYNC_ADDR))
            sync_ctrl <= sync_ctrl_t'(cfg_wdata[SCTL_W-1:0]);
    end

endmodule

// File: rtl/clkdist_sync_ctrl.sv
// Module: merges the four sync sources into one registered hold signal.
// Assumes lock inputs are synchronous to clk; multifunction pins are not
// and pass through two flops before the falling-edge detector.
module clkdist_sync_ctrl
    import clkdist_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  sync_ctrl_t        sync_ctrl,
    input  logic              lock_freq,
    input  logic              lock_phase,
    input  logic [NUM_MF-1:0] mf_pin,
    input  logic              cfg_load_sync,
    output logic              sync_hold
);

    logic [NUM_MF-1:0] pin_m1, pin_m2, pin_prev;
    logic              lf_q, lp_q;
    logic              auto_hit, pin_hit, sync_req;

    // Two-flop synchronizer plus one history stage for every pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_m1   <= '1;
            pin_m2   <= '1;
            pin_prev <= '1;
        end else begin
            pin_m1   <= mf_pin;
            pin_m2   <= pin_m1;
            pin_prev <= pin_m2;
        end
    end

    // Remembers last lock levels for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lf_q <= 1'b0;
            lp_q <= 1'b0;
        end else begin
            lf_q <= lock_freq;
            lp_q <= lock_phase;
        end
    end

    // Combines every enabled source into one request.
    always_comb begin
        auto_hit = (sync_ctrl.auto_freq_en  & lock_freq  & ~lf_q)
                 | (sync_ctrl.auto_phase_en & lock_phase & ~lp_q);
        pin_hit  = sync_ctrl.pin_en & pin_prev[sync_ctrl.pin_sel]
                 & ~pin_m2[sync_ctrl.pin_sel];
        sync_req = sync_ctrl.direct | auto_hit | pin_hit | cfg_load_sync;
    end

    // Registers the request so every divider sees one clean hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_hold <= 1'b0;
        else
            sync_hold <= sync_req;
    end

endmodule

// File: rtl/clkdist_divider.sv
// Module: one channel integer divider with restart-on-hold.
// Assumes the hold is common to all channels; the ratio is captured only
// while held, so a running channel never changes period mid-cycle.
module clkdist_divider #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [DIV_W-1:0] ratio_cfg,
    output logic             wave,
    output logic [DIV_W-1:0] cnt,
    output logic [DIV_W-1:0] ratio_act
);

    localparam int CW = DIV_W + 1;

    logic [DIV_W-1:0] wrap_at;
    logic [CW-1:0]    hi_len;

    // Derives the last count value and the high-phase length.
    always_comb begin
        wrap_at = (ratio_act == '0) ? '0 : ratio_act - 1'b1;
        hi_len  = (ratio_act == '0) ? CW'(1)
                                    : ({1'b0, ratio_act} + CW'(1)) >> 1;
    end

    // Counts through one output period, or clears and reloads while held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            wave      <= 1'b0;
            ratio_act <= '0;
        end else if (hold) begin
            cnt       <= '0;
            wave      <= 1'b0;
            ratio_act <= ratio_cfg;
        end else begin
            wave <= ({1'b0, cnt} < hi_len);
            cnt  <= (cnt == wrap_at) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/clkdist_pin_map.sv
// Module: maps one divided waveform to pin values and enables.
// Assumes a pin whose enable is low in a single-ended mode reads 0.
module clkdist_pin_map
    import clkdist_pkg::*;
(
    input  logic     wave,
    input  ch_ctrl_t ctrl,
    output logic     pin_p,
    output logic     pin_n,
    output logic     en_p,
    output logic     en_n
);

    logic lvl, cmos_n;

    // Applies polarity, phase flip and the mode table.
    always_comb begin
        lvl    = wave ^ ctrl.pol_inv;
        cmos_n = ctrl.cmos_flip ? ~lvl : lvl;
        unique case (ctrl.mode)
            MODE_CMOS_BOTH: begin
                pin_p = lvl;  pin_n = cmos_n; en_p = 1'b1; en_n = 1'b1;
            end
            MODE_CMOS_P: begin
                pin_p = lvl;  pin_n = 1'b0;   en_p = 1'b1; en_n = 1'b0;
            end
            MODE_CMOS_N: begin
                pin_p = 1'b0; pin_n = cmos_n; en_p = 1'b0; en_n = 1'b1;
            end
            MODE_DIFF_A, MODE_DIFF_B: begin
                pin_p = lvl;  pin_n = ~lvl;   en_p = 1'b1; en_n = 1'b1;
            end
            default: begin
                pin_p = lvl;  pin_n = ~lvl;   en_p = 1'b0; en_n = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/clkdist_fanout.sv
// Module: top of the synchronized clock distribution block.
// Assumes DIV_W >= the control and sync field widths (write data is DIV_W).
module clkdist_fanout
    import clkdist_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DIV_W  = 10,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DIV_W-1:0]  cfg_wdata,
    input  logic              lock_freq_i,
    input  logic              lock_phase_i,
    input  logic [NUM_MF-1:0] mf_pin_i,
    input  logic              cfg_load_sync_i,
    output logic [NUM_CH-1:0] out_p_o,
    output logic [NUM_CH-1:0] out_n_o,
    output logic [NUM_CH-1:0] oe_p_o,
    output logic [NUM_CH-1:0] oe_n_o
);

    logic [NUM_CH-1:0][DIV_W-1:0] ratio_cfg;
    logic [NUM_CH-1:0][DIV_W-1:0] div_cnt;
    logic [NUM_CH-1:0][DIV_W-1:0] div_ratio;
    ch_ctrl_t [NUM_CH-1:0]        ch_ctrl;
    sync_ctrl_t                   sync_ctrl;
    logic                         sync_hold;
    logic [NUM_CH-1:0]            wave;

    clkdist_regs #(
        .NUM_CH (NUM_CH),
        .DIV_W  (DIV_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ratio_cfg (ratio_cfg),
        .ch_ctrl   (ch_ctrl),
        .sync_ctrl (sync_ctrl)
    );

    clkdist_sync_ctrl u_sync (
        .clk           (clk),
        .rst_n         (rst_n),
        .sync_ctrl     (sync_ctrl),
        .lock_freq     (lock_freq_i),
        .lock_phase    (lock_phase_i),
        .mf_pin        (mf_pin_i),
        .cfg_load_sync (cfg_load_sync_i),
        .sync_hold     (sync_hold)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        clkdist_divider #(
            .DIV_W (DIV_W)
        ) u_div (
            .clk       (clk),
            .rst_n     (rst_n),
            .hold      (sync_hold),
            .ratio_cfg (ratio_cfg[i]),
            .wave      (wave[i]),
            .cnt       (div_cnt[i]),
            .ratio_act (div_ratio[i])
        );

        clkdist_pin_map u_map (
            .wave  (wave[i]),
            .ctrl  (ch_ctrl[i]),
            .pin_p (out_p_o[i]),
            .pin_n (out_n_o[i]),
            .en_p  (oe_p_o[i]),
            .en_n  (oe_n_o[i])
        );
    end

endmodule

// File: rtl/clkdist_fanout_chk.sv
// Module: property checker bound to clkdist_fanout.
// Assumes it sees the hold, divider state and pins of the top module.
module clkdist_fanout_chk
    import clkdist_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DIV_W  = 10
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         sync_hold,
    input logic [NUM_CH-1:0]            wave,
    input logic [NUM_CH-1:0][DIV_W-1:0] div_cnt,
    input logic [NUM_CH-1:0][DIV_W-1:0] div_ratio,
    input ch_ctrl_t [NUM_CH-1:0]        ch_ctrl,
    input logic [NUM_CH-1:0]            out_p_o,
    input logic [NUM_CH-1:0]            out_n_o,
    input logic [NUM_CH-1:0]            oe_p_o,
    input logic [NUM_CH-1:0]            oe_n_o
);

    // R3: a held cycle leaves every waveform low.
    p_hold_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hold |=> (wave == '0));

    // R3: every counter starts from zero on release.
    p_restart_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_hold) |-> (div_cnt == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R4: the active ratio only changes under hold.
        p_ratio_latched_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !sync_hold |=> $stable(div_ratio[i]));

        // R3: equal ratio and count give equal next waveform.
        if (i > 0) begin : g_pair
            p_lockstep_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (div_ratio[0] == div_ratio[i] && div_cnt[0] == div_cnt[i])
                |=> (wave[0] == wave[i]));
        end

        // R10: mode 000 pin relation follows the flip bit.
        p_cmos_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_ctrl[i].mode == MODE_CMOS_BOTH)
            |-> ((out_n_o[i] == (out_p_o[i] ^ ch_ctrl[i].cmos_flip))
                 && oe_p_o[i] && oe_n_o[i]));

        // R11: mode 001 leaves the negative pin off and low.
        p_half_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_ctrl[i].mode == MODE_CMOS_P)
            |-> (oe_p_o[i] && !oe_n_o[i] && !out_n_o[i]));

        // R12: differential modes give a complementary driven pair.
        p_diff_pair_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_ctrl[i].mode == MODE_DIFF_A || ch_ctrl[i].mode == MODE_DIFF_B)
            |-> ((out_n_o[i] != out_p_o[i]) && oe_p_o[i] && oe_n_o[i]));

        // R12: off and reserved modes drive neither pin.
        p_both_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_ctrl[i].mode == MODE_OFF || ch_ctrl[i].mode == MODE_RSV6
             || ch_ctrl[i].mode == MODE_RSV7)
            |-> (!oe_p_o[i] && !oe_n_o[i]));
    end

endmodule

bind clkdist_fanout clkdist_fanout_chk #(
    .NUM_CH (NUM_CH),
    .DIV_W  (DIV_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_hold (sync_hold),
    .wave      (wave),
    .div_cnt   (div_cnt),
    .div_ratio (div_ratio),
    .ch_ctrl   (ch_ctrl),
    .out_p_o   (out_p_o),
    .out_n_o   (out_n_o),
    .oe_p_o    (oe_p_o),
    .oe_n_o    (oe_n_o)
);

// File: tb/clkdist_fanout_tb_top.sv
// Scoreboard bench: driver tasks queue expected pin vectors, a monitor
// pops one per cycle two time units after each rising edge and compares.
module clkdist_fanout_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [9:0]  cfg_wdata;
    logic        lock_freq, lock_phase, cfg_load;
    logic [7:0]  mf_pin;
    logic [3:0]  out_p, out_n, oe_p, oe_n;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic [15:0] exp_q[$];
    bit          skip_q[$];
    string       tag_q[$];

    int       cfg_ratio[4];
    int       act_ratio[4];
    bit [2:0] m_mode[4];
    bit       m_pol[4];
    bit       m_flip[4];
    bit [6:0] sc;

    always #5 clk = ~clk;

    clkdist_fanout dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_we          (cfg_we),
        .cfg_addr        (cfg_addr),
        .cfg_wdata       (cfg_wdata),
        .lock_freq_i     (lock_freq),
        .lock_phase_i    (lock_phase),
        .mf_pin_i        (mf_pin),
        .cfg_load_sync_i (cfg_load),
        .out_p_o         (out_p),
        .out_n_o         (out_n),
        .oe_p_o          (oe_p),
        .oe_n_o          (oe_n)
    );

    function automatic bit raw_bit(int r, int k);
        int d;
        d = (r == 0) ? 1 : r;
        return (k % d) < ((d + 1) / 2);
    endfunction

    // Expected {oe_n, oe_p, n, p} from the requirement mode table.
    function automatic logic [15:0] pins(logic [3:0] raw);
        logic [3:0] p, n, ep, en;
        bit v, c;
        for (int ch = 0; ch < 4; ch++) begin
            v = raw[ch] ^ m_pol[ch];
            c = m_flip[ch] ? ~v : v;
            case (m_mode[ch])
                3'b000: begin p[ch] = v; n[ch] = c;  ep[ch] = 1; en[ch] = 1; end
                3'b001: begin p[ch] = v; n[ch] = 0;  ep[ch] = 1; en[ch] = 0; end
                3'b010: begin p[ch] = 0; n[ch] = c;  ep[ch] = 0; en[ch] = 1; end
                3'b100, 3'b101:
                        begin p[ch] = v; n[ch] = ~v; ep[ch] = 1; en[ch] = 1; end
                default:
                        begin p[ch] = v; n[ch] = ~v; ep[ch] = 0; en[ch] = 0; end
            endcase
        end
        return {en, ep, n, p};
    endfunction

    task automatic push(bit skip, logic [15:0] v, string t);
        exp_q.push_back(v);
        skip_q.push_back(skip);
        tag_q.push_back(t);
    endtask

    // Queues: skip slots, one held-low slot, then len running slots.
    task automatic expect_run(int skip, int len, string t);
        logic [3:0] raw;
        for (int s = 0; s < skip; s++) push(1, '0, t);
        push(0, pins(4'b0000), t);
        for (int k = 0; k < len; k++) begin
            for (int ch = 0; ch < 4; ch++) raw[ch] = raw_bit(act_ratio[ch], k);
            push(0, pins(raw), t);
        end
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = 10'(d);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic set_ratio(int ch, int r);
        cfg_ratio[ch] = r;
        wr(ch, r);
    endtask

    task automatic set_ctrl(int ch, bit [2:0] md, bit pol, bit flp);
        m_mode[ch] = md; m_pol[ch] = pol; m_flip[ch] = flp;
        wr(4 + ch, {flp, pol, md});
    endtask

    task automatic latch_ratios();
        for (int ch = 0; ch < 4; ch++) act_ratio[ch] = cfg_ratio[ch];
    endtask

    // Sets then clears the direct bit; queue starts at the release.
    task automatic direct_sync(int len, string t);
        sc[0] = 1; wr(8, sc);
        sc[0] = 0; wr(8, sc);
        latch_ratios();
        expect_run(0, len, t);
    endtask

    // Monitor: compares one queued vector per cycle.
    logic [15:0] m_exp;
    bit          m_skip;
    string       m_tag;
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            m_exp  = exp_q.pop_front();
            m_skip = skip_q.pop_front();
            m_tag  = tag_q.pop_front();
            if (!m_skip) begin
                checks++;
                if ({oe_n, oe_p, out_n, out_p} !== m_exp) begin
                    errors++;
                    $display("FAIL %s: actual oen/oep/n/p=%h expected %h at %0t",
                             m_tag, {oe_n, oe_p, out_n, out_p}, m_exp, $time);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
        lock_freq = 0; lock_phase = 0; cfg_load = 0; mf_pin = 8'hFF;
        sc = '0;
        for (int ch = 0; ch < 4; ch++) begin
            cfg_ratio[ch] = 0; act_ratio[ch] = 0;
            m_mode[ch] = 0; m_pol[ch] = 0; m_flip[ch] = 0;
        end
        repeat (3) @(negedge clk);

        // R1: reset state of pins and enables.
        checks++;
        if ({oe_n, oe_p, out_n, out_p} !== 16'hFF00) begin
            errors++;
            $display("FAIL R1 reset: actual %h expected %h",
                     {oe_n, oe_p, out_n, out_p}, 16'hFF00);
        end

        // R1 / R2: defaults give divide-by-1, a constant high level.
        @(negedge clk) rst_n = 1;
        for (int k = 0; k < 6; k++) push(0, pins(4'b1111), "R1 R2 default ratio");
        drain();

        set_ratio(0, 4); set_ratio(1, 3); set_ratio(2, 4); set_ratio(3, 7);

        // R5: direct bit held keeps every channel low.
        sc[0] = 1; wr(8, sc);
        push(1, '0, "R5 hold");
        for (int k = 0; k < 8; k++) push(0, pins(4'b0000), "R5 hold level");
        drain();
        sc[0] = 0; wr(8, sc);
        latch_ratios();
        expect_run(0, 40, "R2 R3 R5 release");
        drain();

        // R4: ratio writes while running wait for the next hold.
        direct_sync(40, "R4 old ratio kept");
        set_ratio(1, 5);
        set_ratio(3, 2);
        drain();
        direct_sync(30, "R4 new ratio");
        drain();

        // R6 / R7: disabled sources leave the running waveform intact.
        direct_sync(60, "R6 R7 disabled sources");
        @(negedge clk) lock_freq = 1;
        @(negedge clk) lock_phase = 1;
        mf_pin[2] = 0;
        repeat (4) @(negedge clk);
        mf_pin = 8'hFF; lock_freq = 0; lock_phase = 0;
        drain();

        // R6: frequency-lock rising edge with its enable set.
        sc[1] = 1; wr(8, sc);
        @(negedge clk) lock_freq = 1;
        latch_ratios();
        expect_run(1, 40, "R6 freq lock edge");
        drain();
        lock_freq = 0;

        // R6: phase-lock rising edge with its enable set.
        sc[1] = 0; sc[2] = 1; wr(8, sc);
        @(negedge clk) lock_phase = 1;
        latch_ratios();
        expect_run(1, 40, "R6 phase lock edge");
        drain();
        lock_phase = 0;
        sc[2] = 0;

        // R7: unselected pin falling edge has no effect.
        sc[3] = 1; sc[6:4] = 3'd5; wr(8, sc);
        direct_sync(40, "R7 unselected pin");
        @(negedge clk) mf_pin[2] = 0;
        repeat (3) @(negedge clk);
        mf_pin[2] = 1;
        drain();

        // R7: selected pin falling edge restarts; its rising edge does not.
        @(negedge clk) mf_pin[5] = 0;
        latch_ratios();
        expect_run(3, 40, "R7 selected pin fall");
        repeat (8) @(negedge clk);
        mf_pin[5] = 1;
        drain();

        // R8: configuration-load strobe restarts.
        set_ratio(1, 1);
        @(negedge clk) cfg_load = 1;
        latch_ratios();
        expect_run(1, 30, "R8 load strobe");
        @(negedge clk) cfg_load = 0;
        drain();

        // R9 R10 R11 R12: first mode set.
        set_ctrl(0, 3'b000, 0, 1);
        set_ctrl(1, 3'b001, 1, 0);
        set_ctrl(2, 3'b010, 0, 1);
        set_ctrl(3, 3'b100, 0, 1);
        direct_sync(30, "R9 R10 R11 R12 set A");
        drain();

        // R9 R10 R11 R12: second mode set.
        set_ctrl(0, 3'b101, 1, 1);
        set_ctrl(1, 3'b011, 0, 0);
        set_ctrl(2, 3'b110, 1, 0);
        set_ctrl(3, 3'b000, 1, 0);
        direct_sync(30, "R9 R10 R12 set B");
        drain();

        // R11 R12: remaining codes and flip on the negative-only mode.
        set_ctrl(0, 3'b010, 1, 0);
        set_ctrl(1, 3'b111, 1, 1);
        set_ctrl(2, 3'b011, 0, 1);
        set_ctrl(3, 3'b001, 0, 1);
        direct_sync(30, "R11 R12 set C");
        drain();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule